// File: doc/BRIEF.md
# Variable-Footprint Retire Queue

This block keeps the program-order record of in-flight instructions in an out-of-order core model. It is a circular array of slots. At dispatch, an instruction claims a run of consecutive slots whose length follows its micro-op count. The block hands back a token, which is the index of the first slot in that run. Each entry records how many slots it covers and whether it has finished executing.

Completion notices arrive later, addressed by token, and set the finished mark of that entry. Retirement is automatic and keeps program order. Each cycle the block walks forward from the oldest entry and retires entries while they are finished. The walk stops at the first unfinished entry or at a configurable per-cycle cap. Each retired entry moves the oldest-entry pointer on by its own slot count and returns its slots to the free pool.

The dispatch logic reads the free count and a ready signal to decide whether to issue. The retire side can watch the oldest entry through the peek outputs.

Top module: `retire_queue_ctrl`

## Requirements
- R1: After reset, the free count equals NUM_SLOTS, the oldest entry reads not valid, the next token is 0, and the retire count is 0.
- R2: An accepted reservation returns as its token the tail index held before the request. The tail then moves on by the reserved footprint, wrapping modulo NUM_SLOTS, and the free count drops by that footprint.
- R3: A micro-op count larger than NUM_SLOTS reserves exactly NUM_SLOTS slots.
- R4: A micro-op count of zero reserves exactly one slot, and the entry shows a slot count of 1.
- R5: Ready is high exactly when the free count is at least the normalized footprint. A request made while ready is low leaves the tail, the free count and all entries unchanged.
- R6: A completion notice carrying a token sets the finished mark of the valid entry at that index. That mark shows on the peek outputs from the next cycle.
- R7: An entry retires only when it is the oldest and is finished. A finished younger entry waits behind an unfinished older one.
- R8: Retiring an entry moves the oldest-entry index forward by that entry's slot count modulo NUM_SLOTS, and adds that count back to the free count.
- R9: At most MAX_RETIRE entries retire per cycle, with MAX_RETIRE of 0 meaning no cap. Entries left over retire in later cycles.
- R10: When a reservation and retirements occur in the same cycle, the free count changes by the retired slots minus the reserved slots.
- R11: A retired entry loses its valid and finished marks, so the peek outputs read not valid once the queue drains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rsv_valid | input | 1 | Reservation request |
| rsv_uops | input | UOP_W | Micro-op count of the request |
| rsv_ready | output | 1 | Enough free slots for the current request |
| rsv_token | output | IDX_W | Token the current request would receive |
| done_valid | input | 1 | Completion notice |
| done_token | input | IDX_W | Token of the finished entry |
| head_valid | output | 1 | Oldest entry is occupied |
| head_token | output | IDX_W | Index of the oldest entry |
| head_slots | output | CNT_W | Slot count of the oldest entry |
| head_done | output | 1 | Oldest entry is finished |
| free_slots | output | CNT_W | Free slot count |
| retire_cnt | output | RC_W | Entries retiring in this cycle |

## Verification
The stimulus mixes micro-op counts of zero, small values, and values above the queue size. This separates the bump-to-one rule from the clamp and from the plain case. Completion notices are sent out of program order, so in-order retirement can be told apart from retiring any finished entry. Three finished single-slot entries expose the per-cycle cap. Reservations that collide with retirements, and a request that overflows the free pool, show whether the free count is updated by the net amount and whether a refused request leaves the state untouched.

// File: rtl/retire_queue_ctrl.sv
module retire_queue_ctrl #(
  parameter int NUM_SLOTS  = 16,
  parameter int UOP_W      = 6,
  parameter int MAX_RETIRE = 4,
  localparam int IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int CNT_W = $clog2(NUM_SLOTS + 1),
  localparam int LANES = (MAX_RETIRE == 0 || MAX_RETIRE > NUM_SLOTS) ? NUM_SLOTS : MAX_RETIRE,
  localparam int RC_W  = $clog2(LANES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rsv_valid,
  input  logic [UOP_W-1:0] rsv_uops,
  output logic             rsv_ready,
  output logic [IDX_W-1:0] rsv_token,
  input  logic             done_valid,
  input  logic [IDX_W-1:0] done_token,
  output logic             head_valid,
  output logic [IDX_W-1:0] head_token,
  output logic [CNT_W-1:0] head_slots,
  output logic             head_done,
  output logic [CNT_W-1:0] free_slots,
  output logic [RC_W-1:0]  retire_cnt
);

  function automatic logic [IDX_W-1:0] wrap_add(input logic [IDX_W-1:0] idx,
                                                input logic [CNT_W-1:0] cnt);
    int s;
    s = int'(idx) + int'(cnt);
    if (s >= NUM_SLOTS) s = s - NUM_SLOTS;
    return IDX_W'(s);
  endfunction

  logic [NUM_SLOTS-1:0] ent_vld, ent_exe;
  logic [CNT_W-1:0]     ent_cnt [NUM_SLOTS];
  logic [IDX_W-1:0]     head_q, tail_q, head_nxt;
  logic [CNT_W-1:0]     free_q, rsv_n, used;
  logic                 accept;

  always_comb begin
    if (rsv_uops == '0)                    rsv_n = CNT_W'(1);
    else if (int'(rsv_uops) > NUM_SLOTS)   rsv_n = CNT_W'(NUM_SLOTS);
    else                                   rsv_n = CNT_W'(rsv_uops);
  end

  assign rsv_ready = free_q >= rsv_n;
  assign accept    = rsv_valid && rsv_ready;
  assign used      = CNT_W'(NUM_SLOTS) - free_q;

  logic [IDX_W-1:0] lane_ptr   [LANES+1];
  logic [CNT_W-1:0] lane_freed [LANES+1];
  logic [LANES:0]   lane_go;

  assign lane_go[0]    = 1'b1;
  assign lane_ptr[0]   = head_q;
  assign lane_freed[0] = '0;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lane_go[k+1]    = lane_go[k] && (lane_freed[k] < used)
                             && ent_vld[lane_ptr[k]] && ent_exe[lane_ptr[k]];
    assign lane_ptr[k+1]   = wrap_add(lane_ptr[k], ent_cnt[lane_ptr[k]]);
    assign lane_freed[k+1] = lane_freed[k] + (lane_go[k+1] ? ent_cnt[lane_ptr[k]] : '0);
  end

  always_comb begin
    head_nxt   = head_q;
    retire_cnt = '0;
    for (int k = 0; k < LANES; k++) begin
      if (lane_go[k+1]) begin
        head_nxt   = lane_ptr[k+1];
        retire_cnt = retire_cnt + RC_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q  <= '0;
      tail_q  <= '0;
      free_q  <= CNT_W'(NUM_SLOTS);
      ent_vld <= '0;
      ent_exe <= '0;
      for (int i = 0; i < NUM_SLOTS; i++) ent_cnt[i] <= '0;
    end else begin
      head_q <= head_nxt;
      free_q <= free_q - (accept ? rsv_n : '0) + lane_freed[LANES];
      for (int k = 0; k < LANES; k++) begin
        if (lane_go[k+1]) begin
          ent_vld[lane_ptr[k]] <= 1'b0;
          ent_exe[lane_ptr[k]] <= 1'b0;
        end
      end
      if (accept) begin
        tail_q          <= wrap_add(tail_q, rsv_n);
        ent_vld[tail_q] <= 1'b1;
        ent_exe[tail_q] <= 1'b0;
        ent_cnt[tail_q] <= rsv_n;
      end
      if (done_valid && ent_vld[done_token]) ent_exe[done_token] <= 1'b1;
    end
  end

  assign rsv_token  = tail_q;
  assign head_valid = ent_vld[head_q];
  assign head_token = head_q;
  assign head_slots = ent_cnt[head_q];
  assign head_done  = ent_exe[head_q];
  assign free_slots = free_q;

endmodule

module retire_queue_ctrl_chk #(
  parameter int NUM_SLOTS = 16,
  parameter int IDX_W     = 4,
  parameter int CNT_W     = 5,
  parameter int RC_W      = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rsv_valid,
  input logic             rsv_ready,
  input logic [CNT_W-1:0] rsv_n,
  input logic [IDX_W-1:0] rsv_token,
  input logic             done_valid,
  input logic             done_hit_vld,
  input logic             done_hit_exe,
  input logic             head_valid,
  input logic             head_done,
  input logic [CNT_W-1:0] free_slots,
  input logic [RC_W-1:0]  retire_cnt
);

  assert_free_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    int'(free_slots) <= NUM_SLOTS);

  assert_reserve_take_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsv_valid && rsv_ready && retire_cnt == '0)
    |=> free_slots == $past(free_slots) - $past(rsv_n));

  assert_reject_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsv_valid && !rsv_ready && retire_cnt == '0)
    |=> ($stable(free_slots) && $stable(rsv_token)));

  assert_ready_room_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsv_ready |-> free_slots != '0);

  assert_in_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_cnt != '0) |-> (head_valid && head_done));

  assert_done_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> (done_hit_vld && !done_hit_exe));

endmodule

bind retire_queue_ctrl retire_queue_ctrl_chk #(
  .NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W), .CNT_W(CNT_W), .RC_W(RC_W)
) chk (
  .clk(clk), .rst_n(rst_n), .rsv_valid(rsv_valid), .rsv_ready(rsv_ready),
  .rsv_n(rsv_n), .rsv_token(rsv_token), .done_valid(done_valid),
  .done_hit_vld(ent_vld[done_token]), .done_hit_exe(ent_exe[done_token]),
  .head_valid(head_valid), .head_done(head_done),
  .free_slots(free_slots), .retire_cnt(retire_cnt)
);

// File: tb/retire_queue_ctrl_test.sv
`timescale 1ns/1ps
module retire_queue_ctrl_test;
  localparam int N = 8, UW = 4, MR = 2;
  localparam int IW = 3, CW = 4, RW = 2;

  logic clk = 0, rst_n = 0;
  logic rsv_valid = 0, done_valid = 0;
  logic [UW-1:0] rsv_uops = '0;
  logic [IW-1:0] done_token = '0;
  logic rsv_ready, head_valid, head_done;
  logic [IW-1:0] rsv_token, head_token;
  logic [CW-1:0] head_slots, free_slots;
  logic [RW-1:0] retire_cnt;
  int n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  retire_queue_ctrl #(.NUM_SLOTS(N), .UOP_W(UW), .MAX_RETIRE(MR)) uut (
    .clk(clk), .rst_n(rst_n), .rsv_valid(rsv_valid), .rsv_uops(rsv_uops),
    .rsv_ready(rsv_ready), .rsv_token(rsv_token), .done_valid(done_valid),
    .done_token(done_token), .head_valid(head_valid), .head_token(head_token),
    .head_slots(head_slots), .head_done(head_done), .free_slots(free_slots),
    .retire_cnt(retire_cnt));

  // row: rsv_v, uops, done_v, done_tok | exp ready, token, free, retire
  localparam int ROWS = 29;
  localparam logic [18:0] VEC [ROWS] = '{
    {1'b1,4'd3, 1'b0,3'd0, 1'b1,3'd0,4'd8,2'd0},   // R2
    {1'b1,4'd0, 1'b0,3'd0, 1'b1,3'd3,4'd5,2'd0},   // R4
    {1'b1,4'd2, 1'b0,3'd0, 1'b1,3'd4,4'd4,2'd0},
    {1'b1,4'd3, 1'b0,3'd0, 1'b0,3'd6,4'd2,2'd0},   // R5 refused
    {1'b0,4'd0, 1'b1,3'd3, 1'b1,3'd6,4'd2,2'd0},   // younger done
    {1'b0,4'd1, 1'b0,3'd0, 1'b1,3'd6,4'd2,2'd0},   // R7 blocked
    {1'b0,4'd1, 1'b1,3'd0, 1'b1,3'd6,4'd2,2'd0},
    {1'b0,4'd1, 1'b0,3'd0, 1'b1,3'd6,4'd2,2'd2},   // R8
    {1'b1,4'd2, 1'b1,3'd4, 1'b1,3'd6,4'd6,2'd0},
    {1'b1,4'd15,1'b0,3'd0, 1'b0,3'd0,4'd4,2'd1},
    {1'b1,4'd4, 1'b1,3'd6, 1'b1,3'd0,4'd6,2'd0},
    {1'b1,4'd1, 1'b0,3'd0, 1'b1,3'd4,4'd2,2'd1},   // R10
    {1'b0,4'd1, 1'b0,3'd0, 1'b1,3'd5,4'd3,2'd0},
    {1'b0,4'd1, 1'b1,3'd0, 1'b1,3'd5,4'd3,2'd0},
    {1'b0,4'd1, 1'b1,3'd4, 1'b1,3'd5,4'd3,2'd1},
    {1'b0,4'd1, 1'b0,3'd0, 1'b1,3'd5,4'd7,2'd1},
    {1'b1,4'd15,1'b0,3'd0, 1'b1,3'd5,4'd8,2'd0},   // R3 clamp
    {1'b1,4'd0, 1'b0,3'd0, 1'b0,3'd5,4'd0,2'd0},
    {1'b0,4'd1, 1'b1,3'd5, 1'b0,3'd5,4'd0,2'd0},
    {1'b0,4'd1, 1'b0,3'd0, 1'b0,3'd5,4'd0,2'd1},
    {1'b0,4'd1, 1'b0,3'd0, 1'b1,3'd5,4'd8,2'd0},
    {1'b1,4'd1, 1'b0,3'd0, 1'b1,3'd5,4'd8,2'd0},
    {1'b1,4'd1, 1'b0,3'd0, 1'b1,3'd6,4'd7,2'd0},
    {1'b1,4'd1, 1'b1,3'd6, 1'b1,3'd7,4'd6,2'd0},
    {1'b0,4'd1, 1'b1,3'd7, 1'b1,3'd0,4'd5,2'd0},
    {1'b0,4'd1, 1'b1,3'd5, 1'b1,3'd0,4'd5,2'd0},
    {1'b0,4'd1, 1'b0,3'd0, 1'b1,3'd0,4'd5,2'd2},   // R9 cap
    {1'b0,4'd1, 1'b0,3'd0, 1'b1,3'd0,4'd7,2'd1},
    {1'b0,4'd1, 1'b0,3'd0, 1'b1,3'd0,4'd8,2'd0}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input bit rv, input int u, input bit dv, input int dt);
    @(negedge clk);
    rsv_valid = rv; rsv_uops = UW'(u); done_valid = dv; done_token = IW'(dt);
    #1;
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1; #1;
    check(free_slots == 8, "R1", "free", free_slots, 8);
    check(!head_valid, "R1", "head_valid", head_valid, 0);
    check(rsv_token == 0, "R1", "token", rsv_token, 0);
    check(retire_cnt == 0, "R1", "retire", retire_cnt, 0);

    for (int r = 0; r < ROWS; r++) begin
      logic [18:0] v;
      v = VEC[r];
      drive(v[18], int'(v[17:14]), v[13], int'(v[12:10]));
      check(rsv_ready == v[9], "R5", $sformatf("row %0d ready", r), rsv_ready, v[9]);
      check(rsv_token == v[8:6], "R2", $sformatf("row %0d token", r), rsv_token, v[8:6]);
      check(free_slots == v[5:2], "R10", $sformatf("row %0d free", r), free_slots, v[5:2]);
      check(retire_cnt == v[1:0], "R7", $sformatf("row %0d retire", r), retire_cnt, v[1:0]);
    end

    drive(0, 1, 0, 0);
    check(!head_valid, "R11", "head_valid after drain", head_valid, 0);
    drive(1, 0, 0, 0);
    check(rsv_token == 0 && rsv_ready, "R4", "token", rsv_token, 0);
    drive(0, 1, 0, 0);
    check(head_valid && head_slots == 1, "R4", "head_slots", head_slots, 1);
    check(!head_done, "R6", "head_done before", head_done, 0);
    check(free_slots == 7, "R4", "free", free_slots, 7);
    drive(0, 1, 1, 0);
    drive(0, 1, 0, 0);
    check(head_done, "R6", "head_done after", head_done, 1);
    check(retire_cnt == 1, "R8", "retire", retire_cnt, 1);
    drive(0, 1, 0, 0);
    check(head_token == 1, "R8", "head index", head_token, 1);
    check(free_slots == 8 && !head_valid, "R11", "free after retire", free_slots, 8);

    drive(1, 5, 0, 0);
    drive(0, 1, 0, 0);
    check(free_slots == 3, "R2", "free before reset", free_slots, 3);
    rst_n = 0;
    @(negedge clk); rst_n = 1; #1;
    check(free_slots == 8 && !head_valid, "R1", "free after reset", free_slots, 8);
    check(rsv_token == 0 && head_token == 0, "R1", "indices after reset", rsv_token, 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule